// File: doc/BRIEF.md
# Tag-Chained Receive DMA Write Engine

This block empties an inter-processor receive FIFO into memory. Each beat takes one quadword (four 32-bit words) from the FIFO head and writes it to a destination address that advances by 16 bytes per beat. A down-counter of quadwords tracks how much is left.

In direct mode, software supplies the address and count, and the engine stops when the count reaches zero. In chained mode, the FIFO itself carries 64-bit control tags between data blocks. When the count is zero, the engine pulls the next tag from the FIFO. The tag reloads the address and the count, and it decides whether the chain goes on or finishes.

One kind of tag, and the final beat of certain transfers, also update a stall address. A downstream consumer uses that address to know how far valid data has been written. This happens only when the channel is chosen as the stall source. Completion is reported with a one-cycle interrupt pulse.

Top module: `rxdma_dest_engine`

## Requirements
- R1: The engine pops the FIFO (one whole quadword slot per pop) only when `fifo_level_i` reports at least 4 words. With 1 to 3 words present it neither pops nor writes.
- R2: A chain tag uses the low 64 bits of its FIFO slot. Bits 15:0 hold the quadword count, bits 27:16 are reserved and ignored, bits 30:28 hold the tag kind, bit 31 is the interrupt flag, and bits 63:32 hold the destination address. Bits 127:64 are padding and are ignored.
- R3: Each data beat writes the FIFO head quadword to the current address. It then adds 16 to the address and subtracts 1 from the count, at most one beat per cycle.
- R4: A tag of kind 0 (plain continue) transfers its data and then fetches another tag.
- R5: A tag of kind 7 (end) finishes the chain once its data is written. Any FIFO content after that data is left unpopped.
- R6: When the tag-interrupt enable is set and a tag's interrupt flag is 1, the chain finishes after that tag's data. With the enable clear, the flag has no effect.
- R7: A tag of kind 1 (continue with stall update) copies its address into the stall address when `stall_sel_i` is 1. When its data count then reaches zero, the stall address takes the final advanced address. With `stall_sel_i` low, the stall address never changes.
- R8: In direct mode with `stall_sel_i` set, the final beat loads the advanced address into the stall address. The data beats of kind 0 or kind 7 tags never change the stall address.
- R9: Direct mode never fetches a tag. It completes as soon as the count is zero, including when it is started with a count of zero.
- R10: On completion the engine raises `irq_o` for exactly one cycle, clears its start bit and drops busy.
- R11: A stop request while busy clears the start bit and busy on the next edge and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_start_i | input | 1 | Start pulse, accepted when idle |
| cfg_stop_i | input | 1 | Stop pulse, aborts a running transfer |
| cfg_chain_i | input | 1 | 1 = chained mode, 0 = direct mode (sampled at start) |
| cfg_tie_i | input | 1 | Tag interrupt enable (sampled at start) |
| cfg_addr_i | input | 32 | Initial destination byte address |
| cfg_qwc_i | input | 16 | Initial quadword count |
| stall_sel_i | input | 1 | This channel is the stall-address source |
| fifo_level_i | input | 8 | Words currently held in the FIFO |
| fifo_qword_i | input | 128 | Head quadword of the FIFO |
| fifo_pop_o | output | 1 | Remove one quadword slot at this edge |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory write byte address |
| mem_wdata_o | output | 128 | Memory write data |
| stall_addr_o | output | 32 | Stall address for the downstream consumer |
| busy_o | output | 1 | Transfer in progress |
| str_o | output | 1 | Start bit |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume that the FIFO never reports a level it cannot back with its head quadword. They also assume that the level and head stay constant between clock edges, and that stop is asserted only while the engine is busy or idle, never as a start. The bench models the FIFO as a queue that advances only on a sampled pop, so the level it drives is always consistent with the queue. The bench also holds the level at three words in some phases, to show that the engine waits for a partial quadword.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    localparam int ADDR_W        = 32;
    localparam int QWC_W         = 16;
    localparam int WORD_W        = 32;
    localparam int WORDS_PER_QW  = 4;
    localparam int QW_W          = WORD_W * WORDS_PER_QW;
    localparam int QW_BYTES      = QW_W / 8;
    localparam int LVL_W         = 8;

    localparam logic [2:0] KIND_CONT       = 3'd0;
    localparam logic [2:0] KIND_CONT_STALL = 3'd1;
    localparam logic [2:0] KIND_END        = 3'd7;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              flag;
        logic [2:0]        kind;
        logic [QWC_W-1:0]  qwc;
    } tag_t;

    typedef struct packed {
        logic              str;
        logic              busy;
        logic              fin;
        logic              chain;
        logic              tie;
        logic              last_stall;
        logic [ADDR_W-1:0] addr;
        logic [QWC_W-1:0]  qwc;
        logic              irq;
    } eng_t;
endpackage

// File: rtl/rxdma_tag_decode.sv
module rxdma_tag_decode
    import rxdma_pkg::*;
(
    input  logic [QW_W-1:0] qword_i,
    output tag_t            tag_o
);
    always_comb begin
        tag_o.qwc  = qword_i[QWC_W-1:0];
        tag_o.kind = qword_i[WORD_W-2 -: 3];
        tag_o.flag = qword_i[WORD_W-1];
        tag_o.addr = qword_i[2*WORD_W-1 -: ADDR_W];
    end
endmodule

// File: rtl/rxdma_stall_reg.sv
module rxdma_stall_reg
    import rxdma_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_i,
    input  logic [ADDR_W-1:0] val_i,
    output logic [ADDR_W-1:0] q_o
);
    logic [ADDR_W-1:0] stall_d, stall_q;

    always_comb begin
        stall_d = stall_q;
        if (upd_i) stall_d = val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) stall_q <= '0;
        else         stall_q <= stall_d;
    end

    assign q_o = stall_q;

    // R7: the stall address moves only when an update is requested
    assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_i |=> $stable(q_o));
endmodule

// File: rtl/rxdma_dest_engine.sv
module rxdma_dest_engine
    import rxdma_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_start_i,
    input  logic              cfg_stop_i,
    input  logic              cfg_chain_i,
    input  logic              cfg_tie_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [QWC_W-1:0]  cfg_qwc_i,
    input  logic              stall_sel_i,
    input  logic [LVL_W-1:0]  fifo_level_i,
    input  logic [QW_W-1:0]   fifo_qword_i,
    output logic              fifo_pop_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [QW_W-1:0]   mem_wdata_o,
    output logic [ADDR_W-1:0] stall_addr_o,
    output logic              busy_o,
    output logic              str_o,
    output logic              irq_o
);
    localparam logic [LVL_W-1:0]  LVL_QW  = LVL_W'(WORDS_PER_QW);
    localparam logic [ADDR_W-1:0] ADDR_QW = ADDR_W'(QW_BYTES);

    eng_t              s_d, s_q;
    tag_t              tag;
    logic              have_qw;
    logic              pop, we, stall_upd;
    logic [ADDR_W-1:0] stall_val, next_addr;

    rxdma_tag_decode u_dec (
        .qword_i (fifo_qword_i),
        .tag_o   (tag)
    );

    rxdma_stall_reg u_stall (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (stall_upd),
        .val_i  (stall_val),
        .q_o    (stall_addr_o)
    );

    assign have_qw   = fifo_level_i >= LVL_QW;
    assign next_addr = s_q.addr + ADDR_QW;

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        pop       = 1'b0;
        we        = 1'b0;
        stall_upd = 1'b0;
        stall_val = next_addr;
        if (!s_q.busy) begin
            if (cfg_start_i) begin
                s_d.str        = 1'b1;
                s_d.busy       = 1'b1;
                s_d.fin        = 1'b0;
                s_d.chain      = cfg_chain_i;
                s_d.tie        = cfg_tie_i;
                s_d.last_stall = 1'b0;
                s_d.addr       = cfg_addr_i;
                s_d.qwc        = cfg_qwc_i;
            end
        end else if (cfg_stop_i || !s_q.str) begin
            s_d.str  = 1'b0;
            s_d.busy = 1'b0;
            s_d.fin  = 1'b0;
        end else if (s_q.qwc == '0) begin
            if (!s_q.chain || s_q.fin) begin
                s_d.str  = 1'b0;
                s_d.busy = 1'b0;
                s_d.fin  = 1'b0;
                s_d.irq  = 1'b1;
            end else if (have_qw) begin
                pop            = 1'b1;
                s_d.addr       = tag.addr;
                s_d.qwc        = tag.qwc;
                s_d.last_stall = (tag.kind == KIND_CONT_STALL);
                if ((s_q.tie && tag.flag) || tag.kind == KIND_END) s_d.fin = 1'b1;
                if (tag.kind == KIND_CONT_STALL && stall_sel_i) begin
                    stall_upd = 1'b1;
                    stall_val = tag.addr;
                end
            end
        end else if (have_qw) begin
            pop      = 1'b1;
            we       = 1'b1;
            s_d.addr = next_addr;
            s_d.qwc  = s_q.qwc - QWC_W'(1);
            if (s_q.qwc == QWC_W'(1) && stall_sel_i && (!s_q.chain || s_q.last_stall))
                stall_upd = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign fifo_pop_o  = pop;
    assign mem_we_o    = we;
    assign mem_addr_o  = s_q.addr;
    assign mem_wdata_o = fifo_qword_i;
    assign busy_o      = s_q.busy;
    assign str_o       = s_q.str;
    assign irq_o       = s_q.irq;

    // R1: a slot is removed only when a whole quadword is present
    assert_pop_needs_qword_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_pop_o |-> fifo_level_i >= LVL_QW);
    // R3: consecutive beats step the address by one quadword
    assert_beat_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o && !cfg_stop_i |=> mem_addr_o == $past(mem_addr_o) + ADDR_QW);
    // R9: direct mode pops only to write data
    assert_direct_no_tag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_pop_o && !s_q.chain |-> mem_we_o);
    // R10: completion pulse lasts one cycle and leaves the engine idle
    assert_irq_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);
    assert_irq_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> !busy_o && !str_o);
    // R11: stopping never signals completion
    assert_stop_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && cfg_stop_i |=> !busy_o && !irq_o && !str_o);
endmodule

// File: tb/rxdma_dest_engine_tb.sv
module rxdma_dest_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_start = 1'b0, cfg_stop = 1'b0, cfg_chain = 1'b0, cfg_tie = 1'b0;
    logic [31:0]  cfg_addr = '0;
    logic [15:0]  cfg_qwc = '0;
    logic         stall_sel = 1'b0;
    logic [7:0]   fifo_level = '0;
    logic [127:0] fifo_qword = '0;
    logic         fifo_pop, mem_we, busy, str, irq;
    logic [31:0]  mem_addr, stall_addr;
    logic [127:0] mem_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxdma_dest_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_start_i(cfg_start), .cfg_stop_i(cfg_stop),
        .cfg_chain_i(cfg_chain), .cfg_tie_i(cfg_tie), .cfg_addr_i(cfg_addr),
        .cfg_qwc_i(cfg_qwc), .stall_sel_i(stall_sel), .fifo_level_i(fifo_level),
        .fifo_qword_i(fifo_qword), .fifo_pop_o(fifo_pop), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .stall_addr_o(stall_addr),
        .busy_o(busy), .str_o(str), .irq_o(irq)
    );

    int           n_chk = 0, n_bad = 0;
    logic [127:0] fq[$];
    logic [127:0] exp_d[$];
    logic [31:0]  exp_a[$];
    logic [31:0]  exp_stall = '0;
    int           thr = 0;        // 0 always, 1 alternate, 2 partial only
    logic         ph = 1'b0;
    logic         pend_pop = 1'b0;
    logic         prev_irq = 1'b0;
    int           irq_cnt = 0;

    task automatic check(input logic ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive_fifo();
        int lv;
        lv = 4 * fq.size();
        if (lv > 252) lv = 252;
        ph = ~ph;
        if (fq.size() == 0) fifo_level = 8'd0;
        else if (thr == 2 || (thr == 1 && ph)) fifo_level = 8'd3;
        else fifo_level = 8'(lv);
        fifo_qword = (fq.size() > 0) ? fq[0] : '0;
    endtask

    task automatic observe();
        pend_pop = fifo_pop;
        if (mem_we) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R5 unexpected write", {96'd0, mem_addr}, 128'd0);
            end else begin
                check(mem_addr == exp_a[0] && mem_wdata == exp_d[0], "R3 write beat",
                      (mem_addr == exp_a[0]) ? mem_wdata : {96'd0, mem_addr},
                      (mem_addr == exp_a[0]) ? exp_d[0] : {96'd0, exp_a[0]});
                void'(exp_a.pop_front());
                void'(exp_d.pop_front());
            end
        end
        if (irq) begin
            irq_cnt++;
            if (prev_irq) check(1'b0, "R10 irq longer than one cycle", 128'd1, 128'd0);
        end
        prev_irq = irq;
    endtask

    task automatic cyc();
        @(negedge clk); #1;
        observe();
        @(posedge clk); #1;
        if (pend_pop && fq.size() > 0) void'(fq.pop_front());
        drive_fifo();
    endtask

    task automatic push_tag(input logic [2:0] kind, input logic flag, input logic [15:0] q,
                            input logic [31:0] a);
        fq.push_back({64'hFACE_0FF1_CE00_BEEF, a, flag, kind, 12'hA5A, q});
    endtask

    task automatic push_data(input int n, input logic [31:0] a, input int run);
        for (int k = 0; k < n; k++) begin
            logic [127:0] d;
            d = {32'(run), 32'(k), ~32'(run), 32'hC0DE_0000 | 32'(k)};
            fq.push_back(d);
            exp_d.push_back(d);
            exp_a.push_back(a + 32'(16 * k));
        end
    endtask

    task automatic run(input int ncyc, input logic ch, input logic tie, input logic sel,
                       input logic [31:0] a, input logic [15:0] q, input int left, input string tagr);
        irq_cnt = 0;
        cfg_chain = ch; cfg_tie = tie; stall_sel = sel; cfg_addr = a; cfg_qwc = q;
        drive_fifo();
        cfg_start = 1'b1;
        cyc();
        cfg_start = 1'b0;
        for (int i = 0; i < ncyc; i++) cyc();
        check(exp_a.size() == 0, {tagr, " all beats written"}, 128'(exp_a.size()), 128'd0);
        check(irq_cnt == 1, "R10 single completion pulse", 128'(irq_cnt), 128'd1);
        check(!busy && !str, "R10 idle after completion", {busy, str}, 128'd0);
        check(fq.size() == left, {tagr, " leftover FIFO slots"}, 128'(fq.size()), 128'(left));
        check(stall_addr == exp_stall, "R7/R8 stall address", {96'd0, stall_addr}, {96'd0, exp_stall});
        fq.delete(); exp_a.delete(); exp_d.delete();
        drive_fifo();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired act=running exp=done");
        report();
        $finish;
    end

    initial begin
        logic [2:0] kinds[3];
        int run_id;
        kinds[0] = 3'd0; kinds[1] = 3'd1; kinds[2] = 3'd7;
        run_id = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive_fifo();
        @(negedge clk); #1;
        check(!busy && !str && !irq && !fifo_pop && !mem_we && stall_addr == 0,
              "R10 reset state", {busy, str, irq, fifo_pop, mem_we}, 128'd0);

        // R9 / R8 direct mode sweep
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 2; s++)
                for (int q = 0; q < 7; q++) begin
                    logic [31:0] a;
                    a = 32'h0001_0000 + 32'(q * 256);
                    thr = t;
                    run_id++;
                    push_data(q, a, run_id);
                    fq.push_back(128'h1234);
                    if (s == 1 && q > 0) exp_stall = a + 32'(16 * q);
                    run(2 * q + 10, 1'b0, 1'b0, s[0], a, 16'(q), 1, "R9");
                end

        // R2 R4 R5 R6 R7 chained sweep
        thr = 1;
        for (int ki = 0; ki < 3; ki++)
            for (int tie = 0; tie < 2; tie++)
                for (int fl = 0; fl < 2; fl++)
                    for (int s = 0; s < 2; s++)
                        for (int q = 0; q < 3; q++) begin
                            logic [31:0] a, b;
                            logic ended;
                            run_id++;
                            a = 32'h0040_0000 + 32'(run_id * 4096);
                            b = 32'h0080_0000 + 32'(run_id * 4096);
                            push_tag(kinds[ki], fl[0], 16'(q), a);
                            push_data(q, a, run_id);
                            ended = (kinds[ki] == 3'd7) || (tie == 1 && fl == 1);
                            if (!ended) begin
                                push_tag(3'd7, 1'b0, 16'd1, b);
                                push_data(1, b, run_id + 1000);
                            end
                            fq.push_back(128'h5678);
                            if (s == 1 && kinds[ki] == 3'd1)
                                exp_stall = (q > 0) ? a + 32'(16 * q) : a;
                            run(40, 1'b1, tie[0], s[0], 32'hFFFF_0000, 16'd0, 1,
                                ended ? "R5/R6" : "R4/R6");
                        end

        // R1 partial quadword and R11 stop
        thr = 2;
        fq.push_back(128'h9ABC);
        irq_cnt = 0;
        cfg_chain = 1'b1; cfg_tie = 1'b0; stall_sel = 1'b1;
        drive_fifo();
        cfg_start = 1'b1;
        cyc();
        cfg_start = 1'b0;
        for (int i = 0; i < 10; i++) cyc();
        check(fq.size() == 1, "R1 partial quadword untouched", 128'(fq.size()), 128'd1);
        check(busy && str, "R1 still waiting", {busy, str}, 128'd3);
        cfg_stop = 1'b1;
        cyc();
        cfg_stop = 1'b0;
        for (int i = 0; i < 5; i++) cyc();
        check(!busy && !str, "R11 stop idles engine", {busy, str}, 128'd0);
        check(irq_cnt == 0, "R11 no interrupt on stop", 128'(irq_cnt), 128'd0);
        check(stall_addr == exp_stall, "R11 stall unchanged", {96'd0, stall_addr}, {96'd0, exp_stall});
        report();
        $finish;
    end
endmodule